// File: doc/BRIEF.md
# Chip-Select Wait-State Stretch Generator

This block lengthens external bus accesses by inserting stretch cycles (wait states) before signalling completion. A control register keeps two independent 3-bit stretch counts. Each chip-select line has its own 2-bit source selector. The selector either turns the line off or makes its accesses use stretch count 0, stretch count 1, or an external active-low wait handshake.

An access begins when `accStart` is sampled high while the block is idle. `accCs` names the chip select being accessed. The block asserts that chip-select line until the cycle in which `accReady` goes high, and releases it on the next cycle. Stretching is applied only in the two expanded operating modes. In every other mode, each access completes in its first cycle. Address decoding and the data path are outside this block.

Top module: `cs_stretch_gen`

## Requirements
- R1: After reset, the register reads 0x77. Stretch count 0 is held in bits [2:0] and stretch count 1 in bits [6:4]. Bits 7 and 3 always read zero.
- R2: A write is accepted at any time, including during an access. The written value, with bits 7 and 3 forced to zero, is read back from the next cycle on.
- R3: The cycle after the accepting edge is access cycle 0. With selector 01 in an expanded mode, the selected line is high in cycles 0..N, where N is stretch count 0. `accReady` is high only in cycle N.
- R4: With selector 10 in an expanded mode, the same timing applies, with N taken from stretch count 1.
- R5: A stretch count of 0 gives `accReady` in cycle 0.
- R6: With selector 11 in an expanded mode, `accReady` comes in the first cycle c >= 2 for which `waitN` was high at the rising edge that began cycle c.
- R7: `opMode` 01 and 11 are the expanded modes. With `opMode` 00 or 10, every access completes in cycle 0, whatever the selector's stretch source or the level of `waitN`.
- R8: With selector 00, the access completes in cycle 0 and no chip-select line is asserted.
- R9: An `accStart` that arrives while an access is in progress is ignored. The active line and the timing do not change.
- R10: The stretch count is captured when the access starts. A register write during the access does not change the access length.
- R11: At most one chip-select line is high at a time. All lines are low in the cycle after `accReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| regRdData | output | 8 | Register read value |
| csSel | input | 2*NUM_CS | Source selector per chip select; line k uses bits [2k+1:2k] |
| accStart | input | 1 | Access start request |
| accCs | input | $clog2(NUM_CS) | Index of the chip select being accessed |
| waitN | input | 1 | External wait, low means hold the access |
| opMode | input | 2 | Operating mode: 01 and 11 are the expanded modes |
| csOut | output | NUM_CS | Active-high chip-select lines |
| accReady | output | 1 | Access completes in this cycle |

## Verification
The bench targets the edges of the stretch range. A count of 0 must give ready in the first cycle, so an off-by-one design would hold the line for a second cycle. A count of 7 must run the full length, so a narrow or wrapping counter would end early. In wait mode, `waitN` is released at, before and after the two-cycle floor. A design that ignores the floor would finish in cycle 0 or 1, and one that samples the wait input late would overrun by a cycle. Extra start requests and register writes land in the middle of accesses; a design that re-latches on these would change the active line or the access length. Non-expanded modes combined with every selector catch stretching that leaks outside the expanded modes.

// File: rtl/cs_stretch_pkg.sv
package cs_stretch_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_VAL0 = 2'b01,
    SRC_VAL1 = 2'b10,
    SRC_WAIT = 2'b11
  } srcSel_t;

  localparam logic [1:0] MODE_NORM_EXP = 2'b01;
  localparam logic [1:0] MODE_EMU_EXP  = 2'b11;

  // control -> datapath
  typedef struct packed {
    logic active;
    logic load;
    logic step;
    logic finish;
  } ctrlStrb_t;

  // datapath -> control
  typedef struct packed {
    logic useWait;
    logic cntZero;
    logic minMet;
    logic waitHi;
  } dpStat_t;

endpackage

// File: rtl/cs_stretch_ctrl.sv
module cs_stretch_ctrl
  import cs_stretch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accStart,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      accReady
);

  logic busyQ;
  logic finish;

  always_comb begin
    finish = busyQ & (stat.useWait ? (stat.minMet & stat.waitHi) : stat.cntZero);
    strb.active = busyQ;
    strb.load   = ~busyQ & accStart;
    strb.step   = busyQ & ~finish;
    strb.finish = finish;
  end

  assign accReady = finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           busyQ <= 1'b0;
    else if (strb.load)  busyQ <= 1'b1;
    else if (finish)     busyQ <= 1'b0;
  end

  // R6
  wait_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && stat.useWait && !stat.minMet) |-> !accReady);

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !accReady && accStart) |=> busyQ);

endmodule

// File: rtl/cs_stretch_dp.sv
module cs_stretch_dp
  import cs_stretch_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int STR_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [7:0]                  regWrData,
  output logic [7:0]                  regRdData,
  input  logic [2*NUM_CS-1:0]         csSel,
  input  logic [$clog2(NUM_CS)-1:0]   accCs,
  input  logic                        waitN,
  input  logic [1:0]                  opMode,
  input  ctrlStrb_t                   strb,
  output dpStat_t                     stat,
  output logic [NUM_CS-1:0]           csOut
);

  localparam int IDX_W   = $clog2(NUM_CS);
  localparam int NUM_VAL = 2;
  localparam int FIELD_W = 4;
  localparam logic [7:0] RD_MASK = 8'h77;
  localparam logic [7:0] RST_VAL = 8'h77;

  logic [7:0]        cfgQ;
  logic [STR_W-1:0]  cntQ;
  logic [1:0]        elapsedQ;
  logic              useWaitQ;
  logic              csEnQ;
  logic [IDX_W-1:0]  csIdxQ;
  logic              waitQ;
  logic [STR_W-1:0]  strVal [NUM_VAL];

  srcSel_t pick;
  logic    expanded;

  for (genvar v = 0; v < NUM_VAL; v++) begin : g_fld
    assign strVal[v] = cfgQ[v*FIELD_W +: STR_W];
  end

  assign regRdData = cfgQ;
  assign pick      = srcSel_t'(csSel[accCs*2 +: 2]);
  assign expanded  = (opMode == MODE_NORM_EXP) || (opMode == MODE_EMU_EXP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= RST_VAL;
    else if (regWrEn) cfgQ <= regWrData & RD_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitQ <= 1'b1;
    else       waitQ <= waitN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      elapsedQ <= '0;
      useWaitQ <= 1'b0;
      csEnQ    <= 1'b0;
      csIdxQ   <= '0;
    end else if (strb.load) begin
      elapsedQ <= '0;
      csIdxQ   <= accCs;
      csEnQ    <= (pick != SRC_OFF);
      useWaitQ <= expanded && (pick == SRC_WAIT);
      if (expanded && pick == SRC_VAL0)      cntQ <= strVal[0];
      else if (expanded && pick == SRC_VAL1) cntQ <= strVal[1];
      else                                   cntQ <= '0;
    end else if (strb.step) begin
      if (cntQ != '0)        cntQ <= cntQ - 1'b1;
      if (elapsedQ != 2'd2)  elapsedQ <= elapsedQ + 1'b1;
    end
  end

  always_comb begin
    stat.useWait = useWaitQ;
    stat.cntZero = (cntQ == '0);
    stat.minMet  = (elapsedQ == 2'd2);
    stat.waitHi  = waitQ;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csOut[g] = strb.active & csEnQ & (csIdxQ == IDX_W'(g));
  end

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csOut));

  // R11
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (csOut == '0));

  // R9
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.finish) |=> $stable(csOut));

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == ($past(regWrData) & RD_MASK)));

endmodule

// File: rtl/cs_stretch_gen.sv
module cs_stretch_gen
  import cs_stretch_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int STR_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [7:0]                  regWrData,
  output logic [7:0]                  regRdData,
  input  logic [2*NUM_CS-1:0]         csSel,
  input  logic                        accStart,
  input  logic [$clog2(NUM_CS)-1:0]   accCs,
  input  logic                        waitN,
  input  logic [1:0]                  opMode,
  output logic [NUM_CS-1:0]           csOut,
  output logic                        accReady
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  cs_stretch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accStart (accStart),
    .stat     (stat),
    .strb     (strb),
    .accReady (accReady)
  );

  cs_stretch_dp #(
    .NUM_CS (NUM_CS),
    .STR_W  (STR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .csSel     (csSel),
    .accCs     (accCs),
    .waitN     (waitN),
    .opMode    (opMode),
    .strb      (strb),
    .stat      (stat),
    .csOut     (csOut)
  );

endmodule

// File: tb/cs_stretch_gen_bench.sv
module cs_stretch_gen_bench;

  localparam int NUM_CS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] csSel = '0;
  logic       accStart = 1'b0;
  logic [1:0] accCs = '0;
  logic       waitN = 1'b1;
  logic [1:0] opMode = 2'b01;
  logic [3:0] csOut;
  logic       accReady;

  int total = 0;
  int bad = 0;
  logic [7:0] cfgModel = 8'h77;

  always #4 clk = ~clk;

  cs_stretch_gen #(.NUM_CS(NUM_CS), .STR_W(3)) u_cs_stretch_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .csSel(csSel), .accStart(accStart), .accCs(accCs),
    .waitN(waitN), .opMode(opMode), .csOut(csOut), .accReady(accReady)
  );

  function automatic int expLen(logic [1:0] sel, logic [1:0] mode, logic [7:0] cfg, int w);
    if (!mode[0] || sel == 2'b00) return 0;
    if (sel == 2'b01) return int'(cfg[2:0]);
    if (sel == 2'b10) return int'(cfg[6:4]);
    return (w > 2) ? w : 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    cfgModel = val & 8'h77;
    check(regRdData == cfgModel, "R1/R2 register readback", regRdData, cfgModel);
  endtask

  task automatic runAccess(int idx, logic [7:0] selVec, logic [1:0] mode, int w,
                           bit pokeStart, bit pokeWrite, string req);
    logic [1:0] sel;
    logic [3:0] expCs;
    int len;
    int badCyc;
    int actLen;
    sel = selVec[idx*2 +: 2];
    len = expLen(sel, mode, cfgModel, w);
    expCs = (sel != 2'b00) ? 4'(1 << idx) : 4'd0;
    badCyc = 0;
    actLen = -1;
    @(negedge clk);
    csSel = selVec; opMode = mode; accCs = 2'(idx); accStart = 1'b1;
    waitN = (w <= 0);
    @(negedge clk);
    accStart = 1'b0;
    for (int j = 0; j <= 40; j++) begin
      if (accReady && actLen < 0) actLen = j;
      if (csOut != expCs || accReady != (j == len)) badCyc++;
      if (j == len) break;
      waitN = (j + 1 >= w);
      if (j == 0 && pokeStart) begin accStart = 1'b1; accCs = 2'((idx + 1) % NUM_CS); end
      else accStart = 1'b0;
      if (j == 0 && pokeWrite) begin
        regWrEn = 1'b1; regWrData = ~cfgModel;
        cfgModel = ~cfgModel & 8'h77;
      end else regWrEn = 1'b0;
      @(negedge clk);
    end
    accStart = 1'b0; regWrEn = 1'b0; waitN = 1'b1;
    check(badCyc == 0, req, actLen, len);
    @(negedge clk);
    check(csOut == 4'd0 && !accReady, "R11 lines low after ready", {accReady, csOut}, 0);
    if (pokeWrite)
      check(regRdData == cfgModel, "R10 write during access kept", regRdData, cfgModel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData == 8'h77, "R1 reset value", regRdData, 8'h77);
    check(csOut == 4'd0 && !accReady, "R11 idle after reset", {accReady, csOut}, 0);

    // R3 with reset counts (7)
    runAccess(0, 8'b11_10_01_01, 2'b01, 0, 0, 0, "R3 count0=7");
    runAccess(1, 8'b11_10_10_01, 2'b11, 0, 0, 0, "R4 count1=7");
    writeReg(8'hFF);
    check(regRdData[7] == 1'b0 && regRdData[3] == 1'b0, "R1 reserved bits zero", regRdData, 8'h77);
    writeReg(8'h30);
    runAccess(2, 8'b00_01_00_00, 2'b01, 0, 0, 0, "R5 count0=0");
    runAccess(3, 8'b10_00_00_00, 2'b01, 0, 0, 0, "R4 count1=3");
    writeReg(8'h05);
    runAccess(3, 8'b10_00_00_00, 2'b11, 0, 0, 0, "R5 count1=0");
    // R6 wait handshake
    runAccess(0, 8'h03, 2'b01, 0, 0, 0, "R6 wait released, floor 2");
    runAccess(0, 8'h03, 2'b01, 1, 0, 0, "R6 wait w=1");
    runAccess(0, 8'h03, 2'b01, 2, 0, 0, "R6 wait w=2");
    runAccess(0, 8'h03, 2'b11, 5, 0, 0, "R6 wait w=5");
    // R7 non-expanded modes
    runAccess(1, 8'hFF, 2'b00, 6, 0, 0, "R7 mode 00 wait ignored");
    runAccess(1, 8'h55, 2'b10, 0, 0, 0, "R7 mode 10 count ignored");
    // R8 disabled
    runAccess(2, 8'h00, 2'b01, 0, 0, 0, "R8 disabled line");
    runAccess(2, 8'h00, 2'b00, 0, 0, 0, "R8 disabled non-expanded");
    // R9 / R10 pokes
    writeReg(8'h64);
    runAccess(0, 8'h55, 2'b01, 0, 1, 0, "R9 restart ignored");
    runAccess(1, 8'hAA, 2'b01, 0, 0, 1, "R10 latched count");
    runAccess(0, 8'hFF, 2'b01, 4, 1, 1, "R9 R10 wait access");

    for (int n = 0; n < 300; n++) begin
      int idx;
      logic [1:0] mode;
      int w;
      logic [7:0] selVec;
      if (n % 10 == 0) writeReg(8'($urandom));
      idx = int'($urandom % NUM_CS);
      mode = 2'($urandom);
      w = int'($urandom % 7);
      selVec = 8'($urandom);
      runAccess(idx, selVec, mode, w, bit'($urandom % 2), bit'($urandom % 4 == 0),
                "R3 R4 R6 R7 R8 random access");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule